// File: doc/BRIEF.md
# Keyboard Character Input Port

This block sits on a 16-bit processor bus and presents one received keyboard character to software. A keyboard-side source delivers an 8-bit character code with a one-cycle valid strobe. The port holds the code in a data register and raises a ready flag in a status register. Software finds the character by polling the status register or by taking an interrupt, then reads the data register.

Only one character is held at a time. Once a character is pending, the port refuses all further input until software reads the data register. That read clears the ready flag and opens the port for the next character. Software owns one bit, an interrupt enable in the status register. The interrupt request line is high whenever the ready flag and the enable bit are both set.

Read data is combinational. It is valid in the same cycle as the read strobe, and any side effect of the read takes place at the clock edge that ends the cycle.

Top module: `kbd_input_port`

## Requirements
- R1: After reset the ready flag, the interrupt-enable bit and the data register are all zero, and irqReq is low.
- R2: The status register is decoded at address 0xF400 and the data register at 0xF401. A read of any other address returns zero, and busRdata is zero in any cycle where busRead is low.
- R3: A keyValid pulse that is accepted loads keyCode into data register bits [7:0], with bits [15:8] reading zero. At the same edge it sets the ready flag, which is status bit 15.
- R4: While the ready flag is set, any arriving character is discarded, and the data register keeps its earlier value.
- R5: A cycle with busRead high at 0xF401 clears the ready flag at the next edge, and the next character is then accepted.
- R6: Reading the status register changes nothing. A write to the data register has no effect.
- R7: A write to 0xF400 sets the interrupt-enable bit (status bit 14) from busWdata[14]. The other status bits read zero, and the write never changes the ready flag.
- R8: irqReq is high exactly when the ready flag and the interrupt-enable bit are both one.
- R9: When a character arrives in the same cycle as a data register read, the read returns the old character. The new character is loaded, and the ready flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| keyValid | input | 1 | One-cycle strobe marking a new character |
| keyCode | input | 8 | Character code that comes with keyValid |
| busAddr | input | 16 | CPU bus address |
| busRead | input | 1 | CPU read strobe |
| busWrite | input | 1 | CPU write strobe |
| busWdata | input | 16 | CPU write data |
| busRdata | output | 16 | CPU read data, combinational |
| irqReq | output | 1 | Level interrupt request |

## Verification
The bench sends a second character while one is still pending. A port without lockout would overwrite the unread code. It reads the status register repeatedly and writes the data register. A design that clears the ready flag on the wrong access would lose a pending character. Status writes are made with bit 15 both set and clear, which catches a ready flag that software can alter. The bench also drives a character in the same cycle as a data read. A design with the wrong priority there would either drop the new character or return it in place of the old one.

// File: rtl/kbd_port_pkg.sv
package kbd_port_pkg;
  parameter int ADDR_W   = 16;
  parameter int DATA_W   = 16;
  parameter int CODE_W   = 8;
  parameter logic [15:0] STATUS_ADDR = 16'hF400;
  parameter logic [15:0] DATA_ADDR   = 16'hF401;
  parameter int READY_BIT = 15;
  parameter int IE_BIT    = 14;

  typedef struct packed {
    logic loadChar;   // capture keyCode into the data register
    logic ieWrite;    // update interrupt enable from write data
    logic selStatus;  // drive status word onto read bus
    logic selData;    // drive data word onto read bus
  } portStrobes_t;
endpackage

// File: rtl/kbd_port_ctrl.sv
module kbd_port_ctrl
  import kbd_port_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          keyValid,
  input  logic [AW-1:0] busAddr,
  input  logic          busRead,
  input  logic          busWrite,
  output portStrobes_t  strobes,
  output logic          readyFlag
);
  logic statusHit;
  logic dataHit;
  logic dataRd;
  logic accept;

  always_comb begin
    statusHit = (busAddr == AW'(STATUS_ADDR));
    dataHit   = (busAddr == AW'(DATA_ADDR));
    dataRd    = busRead && dataHit;
    // a data read in the same cycle frees the slot for the arriving code
    accept    = keyValid && (!readyFlag || dataRd);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readyFlag <= 1'b0;
    end else if (accept) begin
      readyFlag <= 1'b1;
    end else if (dataRd) begin
      readyFlag <= 1'b0;
    end
  end

  always_comb begin
    strobes.loadChar  = accept;
    strobes.ieWrite   = busWrite && statusHit;
    strobes.selStatus = busRead && statusHit;
    strobes.selData   = busRead && dataHit;
  end
endmodule

// File: rtl/kbd_port_dpath.sv
module kbd_port_dpath
  import kbd_port_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int CW = CODE_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [CW-1:0] keyCode,
  input  logic [DW-1:0] busWdata,
  input  portStrobes_t  strobes,
  input  logic          readyFlag,
  output logic [DW-1:0] busRdata,
  output logic          irqReq
);
  localparam int PAD_W = DW - CW;

  logic [CW-1:0] charReg;
  logic          ieBit;
  logic [DW-1:0] statusWord;
  logic [DW-1:0] dataWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      charReg <= '0;
      ieBit   <= 1'b0;
    end else begin
      if (strobes.loadChar) charReg <= keyCode;
      if (strobes.ieWrite)  ieBit   <= busWdata[IE_BIT];
    end
  end

  always_comb begin
    statusWord            = '0;
    statusWord[READY_BIT] = readyFlag;
    statusWord[IE_BIT]    = ieBit;
    dataWord              = {{PAD_W{1'b0}}, charReg};
    if (strobes.selStatus)    busRdata = statusWord;
    else if (strobes.selData) busRdata = dataWord;
    else                      busRdata = '0;
    irqReq = readyFlag & ieBit;
  end
endmodule

// File: rtl/kbd_input_port.sv
module kbd_input_port
  import kbd_port_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        keyValid,
  input  logic [7:0]  keyCode,
  input  logic [15:0] busAddr,
  input  logic        busRead,
  input  logic        busWrite,
  input  logic [15:0] busWdata,
  output logic [15:0] busRdata,
  output logic        irqReq
);
  portStrobes_t strobes;
  logic         readyFlag;

  kbd_port_ctrl #(.AW(16)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .keyValid (keyValid),
    .busAddr  (busAddr),
    .busRead  (busRead),
    .busWrite (busWrite),
    .strobes  (strobes),
    .readyFlag(readyFlag)
  );

  kbd_port_dpath #(.DW(16), .CW(8)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .keyCode  (keyCode),
    .busWdata (busWdata),
    .strobes  (strobes),
    .readyFlag(readyFlag),
    .busRdata (busRdata),
    .irqReq   (irqReq)
  );
endmodule

// File: rtl/kbd_input_port_chk.sv
module kbd_input_port_chk (
  input logic        clk,
  input logic        rstN,
  input logic        keyValid,
  input logic [7:0]  keyCode,
  input logic [15:0] busAddr,
  input logic        busRead,
  input logic        busWrite,
  input logic [15:0] busRdata,
  input logic        irqReq,
  input logic        readyFlag,
  input logic [7:0]  charReg
);
  logic dataRd;
  logic statusRd;
  logic statusWr;
  assign dataRd   = busRead  && (busAddr == 16'hF401);
  assign statusRd = busRead  && (busAddr == 16'hF400);
  assign statusWr = busWrite && (busAddr == 16'hF400);

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busRead && busAddr != 16'hF400 && busAddr != 16'hF401) |-> busRdata == 16'h0000); // R2
  AST_ACCEPT_LOADS: assert property (@(posedge clk) disable iff (!rstN)
    (keyValid && !readyFlag) |=> (readyFlag && charReg == $past(keyCode))); // R3
  AST_LOCKOUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (keyValid && readyFlag && !dataRd) |=> $stable(charReg)); // R4
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (dataRd && !keyValid) |=> !readyFlag); // R5
  AST_STATUS_READ_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (statusRd && readyFlag) |=> readyFlag); // R6
  AST_READY_NOT_WRITABLE: assert property (@(posedge clk) disable iff (!rstN)
    (statusWr && readyFlag) |=> readyFlag); // R7
  AST_IRQ_MATCHES_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    statusRd |-> (irqReq == (busRdata[15] & busRdata[14]))); // R8
  AST_SAME_CYCLE_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (dataRd && keyValid) |=> readyFlag); // R9
endmodule

bind kbd_input_port kbd_input_port_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .keyValid (keyValid),
  .keyCode  (keyCode),
  .busAddr  (busAddr),
  .busRead  (busRead),
  .busWrite (busWrite),
  .busRdata (busRdata),
  .irqReq   (irqReq),
  .readyFlag(readyFlag),
  .charReg  (u_dpath.charReg)
);

// File: tb/kbd_input_port_tb.sv
module kbd_input_port_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        keyValid = 1'b0;
  logic [7:0]  keyCode = '0;
  logic [15:0] busAddr = '0;
  logic        busRead = 1'b0;
  logic        busWrite = 1'b0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic        irqReq;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  localparam logic [15:0] ST = 16'hF400;
  localparam logic [15:0] DT = 16'hF401;

  kbd_input_port u_dut (
    .clk(clk), .rstN(rstN), .keyValid(keyValid), .keyCode(keyCode),
    .busAddr(busAddr), .busRead(busRead), .busWrite(busWrite),
    .busWdata(busWdata), .busRdata(busRdata), .irqReq(irqReq)
  );

  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doRead(input logic [15:0] addr, output logic [15:0] val);
    @(negedge clk);
    busAddr = addr; busRead = 1'b1;
    #1 val = busRdata;
    @(negedge clk);
    busRead = 1'b0; busAddr = '0;
  endtask

  task automatic doWrite(input logic [15:0] addr, input logic [15:0] val);
    @(negedge clk);
    busAddr = addr; busWrite = 1'b1; busWdata = val;
    @(negedge clk);
    busWrite = 1'b0; busAddr = '0; busWdata = '0;
  endtask

  task automatic sendKey(input logic [7:0] code);
    @(negedge clk);
    keyValid = 1'b1; keyCode = code;
    @(negedge clk);
    keyValid = 1'b0; keyCode = '0;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    #1 check("R1 irq after reset", {15'd0, irqReq}, 16'h0000);
    doRead(ST, v); check("R1 status after reset", v, 16'h0000);
    doRead(DT, v); check("R1 data after reset", v, 16'h0000);
  endtask

  task automatic t_accept();
    logic [15:0] v;
    sendKey(8'h41);
    doRead(ST, v); check("R3 ready set", v, 16'h8000);
    doRead(DT, v); check("R3 data loaded high byte zero", v, 16'h0041);
    doRead(ST, v); check("R5 ready cleared by data read", v, 16'h0000);
  endtask

  task automatic t_lockout();
    logic [15:0] v;
    sendKey(8'h5A);
    sendKey(8'h33);
    doRead(ST, v); check("R4 ready still set", v, 16'h8000);
    doRead(DT, v); check("R4 second char discarded", v, 16'h005A);
    sendKey(8'hC3);
    doRead(DT, v); check("R5 input re-enabled", v, 16'h00C3);
  endtask

  task automatic t_quiet();
    logic [15:0] v;
    sendKey(8'h10);
    doRead(ST, v); check("R6 status read 1", v, 16'h8000);
    doRead(ST, v); check("R6 status read 2 no side effect", v, 16'h8000);
    doWrite(DT, 16'hFFFF);
    doRead(DT, v); check("R6 data write ignored", v, 16'h0010);
  endtask

  task automatic t_irq();
    logic [15:0] v;
    doWrite(ST, 16'h4000);
    doRead(ST, v); check("R7 ie set", v, 16'h4000);
    check("R8 irq low without ready", {15'd0, irqReq}, 16'h0000);
    sendKey(8'h22);
    #1 check("R8 irq high", {15'd0, irqReq}, 16'h0001);
    doWrite(ST, 16'h0000);
    #1 check("R8 irq low after ie cleared", {15'd0, irqReq}, 16'h0000);
    doRead(ST, v); check("R7 ready kept on status write", v, 16'h8000);
    doWrite(ST, 16'h7FFF);
    doRead(ST, v); check("R7 only bit14 writable", v, 16'hC000);
    doRead(DT, v); check("R3 data for irq char", v, 16'h0022);
    #1 check("R8 irq low after data read", {15'd0, irqReq}, 16'h0000);
    doWrite(ST, 16'h8000);
    doRead(ST, v); check("R7 ready not settable", v, 16'h0000);
  endtask

  task automatic t_decode();
    logic [15:0] v;
    sendKey(8'h7E);
    doRead(16'hF402, v); check("R2 unmapped F402", v, 16'h0000);
    doRead(16'hF3FF, v); check("R2 unmapped F3FF", v, 16'h0000);
    doRead(16'h0000, v); check("R2 unmapped 0000", v, 16'h0000);
    @(negedge clk); busAddr = DT; #1 check("R2 zero without strobe", busRdata, 16'h0000);
    busAddr = '0;
    doRead(ST, v); check("R2 pending kept", v, 16'h8000);
    doRead(DT, v); check("R2 data decode", v, 16'h007E);
  endtask

  task automatic t_same_cycle();
    logic [15:0] v;
    sendKey(8'h61);
    @(negedge clk);
    busAddr = DT; busRead = 1'b1; keyValid = 1'b1; keyCode = 8'h62;
    #1 v = busRdata;
    check("R9 read returns old char", v, 16'h0061);
    @(negedge clk);
    busRead = 1'b0; keyValid = 1'b0; busAddr = '0; keyCode = '0;
    doRead(ST, v); check("R9 ready stays set", v, 16'h8000);
    doRead(DT, v); check("R9 new char accepted", v, 16'h0062);
    doRead(ST, v); check("R9 ready cleared after", v, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_accept();
    t_lockout();
    t_quiet();
    t_irq();
    t_decode();
    t_same_cycle();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule